// File: doc/BRIEF.md
# Power-Down and Reset Sequencer

This block sequences power-down and reset for the control side of a laser driver. A single host pin serves two purposes. Held high, it parks the driver in power-down with both current references off. Released, it starts a reset sequence: the references stay off for a fixed initialisation window and then come back. During that window, a low transmit-power fault is blanked so that it cannot trip the safety shutdown path. The supply-good input acts as the block's power-on reset.

Each completed initialisation, whether it follows power-up or a release of the pin, raises a sticky reset-done flag and an interrupt request. The flag keeps a count of pending completions, up to two. The host clears it with a one-cycle strobe, and must clear it once for each completion. If the supply comes up while the pin is held high, there are two completions to clear: the one from power-up and the one from the later release of the pin. A pin pulse with the supply already on leaves only one.

Top module: `pwrdn_rst_seq`

## Requirements
- R1: Once the synchronised pin has stayed high for MIN_PULSE consecutive cycles, mod_en and bias_en go low. A high level that lasts fewer cycles changes neither enable nor the reset-done count.
- R2: irq stays low while the synchronised pin is high and while the block is in power-down, even when completions are pending.
- R3: If the pin is high when supply_ok rises, the power-up initialisation still completes and raises reset-done. The block then stays in power-down, with both enables low.
- R4: When a recognised pulse is released, the enables stay low for INIT_DELAY cycles of initialisation and then return high. Reset-done rises in that same cycle, SYNC_STAGES+W+INIT_DELAY+1 rising edges after the pin rises, where W is the pulse width in cycles.
- R5: lowp_fault_q equals lowp_fault only while the block runs with its enables on and the synchronised pin is low. At all other times it is 0.
- R6: After supply_ok rises with the pin low, reset-done and both enables rise at the INIT_DELAY-th rising edge.
- R7: Each completion adds one to a pending count that saturates at PEND_MAX (2). Each done_clr strobe removes one, and a strobe at zero has no effect. done_flag is high while the count is non-zero.
- R8: irq is high when done_flag is high and the conditions of R2 do not hold.
- R9: A done_clr strobe in the same cycle as a completion leaves the pending count unchanged.
- R10: While supply_ok is low, the count is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| supply_ok | input | 1 | Supply-good level; low acts as asynchronous reset |
| pdrst_in | input | 1 | Power-down / reset pin, asynchronous |
| lowp_fault | input | 1 | Raw low transmit-power fault, synchronous |
| done_clr | input | 1 | Host write-to-clear strobe for reset-done |
| mod_en | output | 1 | Modulation current reference enable |
| bias_en | output | 1 | Bias current reference enable |
| lowp_fault_q | output | 1 | Low-power fault after blanking |
| done_flag | output | 1 | Sticky reset-done status |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that lowp_fault and done_clr change only on the block's clock, and that done_clr is a strobe that lasts a single cycle. They also assume that supply_ok falls only as a reset, never as a glitch that is sampled. The bench drives every input at the falling clock edge and pulses done_clr for exactly one cycle. It keeps the pin steady across each full pulse, so each pulse width the sweep tries matches the edge count of that pulse.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

   typedef enum logic [1:0] {
      PDR_INIT  = 2'd0,
      PDR_RUN   = 2'd1,
      PDR_PDOWN = 2'd2
   } pdr_state_e;

endpackage

// File: rtl/pdr_sync.sv
module pdr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= 1'b0;
            else        sr <= d;
         end
         assign q = sr;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pdr_pulse_filter.sv
module pdr_pulse_filter #(
   parameter int unsigned MIN_PULSE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pd_req
);
   generate
      if (MIN_PULSE <= 1) begin : g_direct
         assign pd_req = lvl;
      end else begin : g_count
         localparam int unsigned LIM = MIN_PULSE - 1;
         localparam int unsigned CW  = $clog2(MIN_PULSE);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (!lvl)               cnt <= '0;
            else if (cnt != CW'(LIM))    cnt <= cnt + 1'b1;
         end
         assign pd_req = lvl && (cnt == CW'(LIM));
      end
   endgenerate
endmodule

// File: rtl/pdr_fsm.sv
module pdr_fsm
   import pdr_pkg::*;
#(
   parameter int unsigned INIT_DELAY = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pd_req,
   output pdr_state_e state,
   output logic       init_done
);
   localparam int unsigned TW   = (INIT_DELAY > 1) ? $clog2(INIT_DELAY) : 1;
   localparam int unsigned LAST = INIT_DELAY - 1;

   pdr_state_e    nxt;
   logic [TW-1:0] tmr;

   assign init_done = (state == PDR_INIT) && (tmr == TW'(LAST));

   always_comb begin
      nxt = state;
      unique case (state)
         PDR_INIT:  if (init_done) nxt = pd_req ? PDR_PDOWN : PDR_RUN;
         PDR_RUN:   if (pd_req)    nxt = PDR_PDOWN;
         PDR_PDOWN: if (!pd_req)   nxt = PDR_INIT;
         default:                  nxt = PDR_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PDR_INIT;
         tmr   <= '0;
      end else begin
         state <= nxt;
         if (state != PDR_INIT || init_done) tmr <= '0;
         else                                tmr <= tmr + 1'b1;
      end
   end
endmodule

// File: rtl/pdr_done_acct.sv
module pdr_done_acct #(
   parameter int unsigned PEND_MAX = 2,
   localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          clr,
   output logic [PW-1:0] pend,
   output logic          flag
);
   logic [PW:0] sum;

   always_comb begin
      sum = {1'b0, pend} + (PW+1)'(inc);
      if (clr && sum != '0)         sum = sum - 1'b1;
      if (sum > (PW+1)'(PEND_MAX))  sum = (PW+1)'(PEND_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= sum[PW-1:0];
   end

   assign flag = (pend != '0);
endmodule

// File: rtl/pwrdn_rst_seq.sv
module pwrdn_rst_seq
   import pdr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_PULSE   = 4,
   parameter int unsigned INIT_DELAY  = 1000,
   parameter int unsigned PEND_MAX    = 2
) (
   input  logic clk,
   input  logic supply_ok,
   input  logic pdrst_in,
   input  logic lowp_fault,
   input  logic done_clr,
   output logic mod_en,
   output logic bias_en,
   output logic lowp_fault_q,
   output logic done_flag,
   output logic irq
);
   localparam int unsigned PW = $clog2(PEND_MAX + 1);

   generate
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("MIN_PULSE must be at least 1");
      end
      if (INIT_DELAY < 1) begin : g_bad_delay
         $error("INIT_DELAY must be at least 1");
      end
      if (PEND_MAX < 1) begin : g_bad_pend
         $error("PEND_MAX must be at least 1");
      end
   endgenerate

   logic          pin_s;
   logic          pd_req;
   pdr_state_e    state;
   logic          init_done;
   logic [PW-1:0] pend;
   logic          running;
   logic          blank;

   pdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(supply_ok), .d(pdrst_in), .q(pin_s)
   );

   pdr_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
      .clk(clk), .rst_n(supply_ok), .lvl(pin_s), .pd_req(pd_req)
   );

   pdr_fsm #(.INIT_DELAY(INIT_DELAY)) u_fsm (
      .clk(clk), .rst_n(supply_ok), .pd_req(pd_req),
      .state(state), .init_done(init_done)
   );

   pdr_done_acct #(.PEND_MAX(PEND_MAX)) u_acct (
      .clk(clk), .rst_n(supply_ok), .inc(init_done), .clr(done_clr),
      .pend(pend), .flag(done_flag)
   );

   assign running      = (state == PDR_RUN);
   assign blank        = !running || pin_s;
   assign mod_en       = running;
   assign bias_en      = running;
   assign lowp_fault_q = lowp_fault && !blank;
   assign irq          = done_flag && (state != PDR_PDOWN) && !pin_s;
endmodule

// File: rtl/pwrdn_rst_seq_chk.sv
module pwrdn_rst_seq_chk
   import pdr_pkg::*;
#(
   parameter int unsigned PEND_MAX = 2,
   localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
   input logic          clk,
   input logic          supply_ok,
   input logic          pin_s,
   input logic          pd_req,
   input pdr_state_e    state,
   input logic          init_done,
   input logic [PW-1:0] pend,
   input logic          done_clr,
   input logic          mod_en,
   input logic          bias_en,
   input logic          lowp_fault_q,
   input logic          done_flag,
   input logic          irq
);
   assert_pd_drops_en_R1: assert property (@(posedge clk) disable iff (!supply_ok)
      pd_req |=> (!mod_en && !bias_en));

   assert_irq_quiet_R2: assert property (@(posedge clk) disable iff (!supply_ok)
      (state == PDR_PDOWN || pin_s) |-> !irq);

   assert_pwrup_pdown_R3: assert property (@(posedge clk) disable iff (!supply_ok)
      (init_done && pd_req) |=> (state == PDR_PDOWN));

   assert_en_after_init_R4: assert property (@(posedge clk) disable iff (!supply_ok)
      $rose(mod_en) |-> $past(init_done));

   assert_blank_R5: assert property (@(posedge clk) disable iff (!supply_ok)
      !mod_en |-> !lowp_fault_q);

   assert_pend_cap_R7: assert property (@(posedge clk) disable iff (!supply_ok)
      pend <= PW'(PEND_MAX));

   assert_clr_dec_R7: assert property (@(posedge clk) disable iff (!supply_ok)
      (done_clr && !init_done && pend != '0) |=> (pend == $past(pend) - 1'b1));

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      irq |-> done_flag);

   assert_inc_clr_hold_R9: assert property (@(posedge clk) disable iff (!supply_ok)
      (init_done && done_clr) |=> (pend == $past(pend)));
endmodule

bind pwrdn_rst_seq pwrdn_rst_seq_chk #(.PEND_MAX(PEND_MAX)) u_chk (
   .clk(clk), .supply_ok(supply_ok), .pin_s(pin_s), .pd_req(pd_req),
   .state(state), .init_done(init_done), .pend(pend), .done_clr(done_clr),
   .mod_en(mod_en), .bias_en(bias_en), .lowp_fault_q(lowp_fault_q),
   .done_flag(done_flag), .irq(irq)
);

// File: tb/pwrdn_rst_seq_tb.sv
module pwrdn_rst_seq_tb;
   localparam int N = 2;
   localparam int M = 3;
   localparam int D = 8;
   localparam int PMAX = 2;

   logic clk = 1'b0;
   logic supply_ok = 1'b0, pdrst_in = 1'b0, lowp_fault = 1'b0, done_clr = 1'b0;
   logic mod_en, bias_en, lowp_fault_q, done_flag, irq;

   int checks = 0;
   int fails  = 0;
   int ep     = 0;

   always #4 clk = ~clk;

   pwrdn_rst_seq #(.SYNC_STAGES(N), .MIN_PULSE(M), .INIT_DELAY(D), .PEND_MAX(PMAX)) u_dut (
      .clk(clk), .supply_ok(supply_ok), .pdrst_in(pdrst_in), .lowp_fault(lowp_fault),
      .done_clr(done_clr), .mod_en(mod_en), .bias_en(bias_en),
      .lowp_fault_q(lowp_fault_q), .done_flag(done_flag), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_clear(input string tag);
      @(negedge clk); done_clr = 1'b1;
      @(posedge clk); #1;
      ep = (ep > 0) ? ep - 1 : 0;
      chk(tag, done_flag, ep != 0);
      @(negedge clk); done_clr = 1'b0;
   endtask

   // Pulse of w cycles with the model run per cycle; optional clear at the completion edge.
   task automatic pulse(input int w, input bit detail, input bit clr_on_inc);
      bit rec;
      int kdone;
      rec   = (w >= M);
      kdone = N + w + D + 1;
      @(negedge clk); pdrst_in = 1'b1;
      if (clr_on_inc && kdone == 1) done_clr = 1'b1;
      for (int k = 1; k <= kdone + 3; k++) begin
         bit pin_k, pd_k, run_k;
         @(posedge clk); #1;
         if (rec && k == kdone) ep = (ep + 1 - (clr_on_inc ? 1 : 0) > PMAX) ? PMAX : ep + 1 - (clr_on_inc ? 1 : 0);
         pin_k = (k >= N) && (k <= N + w - 1);
         pd_k  = rec && (k >= N + M) && (k <= N + w);
         run_k = !(rec && (k >= N + M) && (k <= N + w + D));
         if (detail) begin
            chk("R1/R4 mod_en", mod_en, run_k);
            chk("R1/R4 bias_en", bias_en, run_k);
            chk("R5 lowp_fault_q", lowp_fault_q, lowp_fault && run_k && !pin_k);
            chk("R4/R7 done_flag", done_flag, ep != 0);
            chk("R2/R8 irq", irq, (ep != 0) && !pd_k && !pin_k);
         end
         @(negedge clk);
         if (k == w) pdrst_in = 1'b0;
         done_clr = (clr_on_inc && k + 1 == kdone);
      end
      done_clr = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int cnt;
      // R10: reset state, fault held high
      lowp_fault = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 mod_en", mod_en, 0);
      chk("R10 bias_en", bias_en, 0);
      chk("R10 lowp_fault_q", lowp_fault_q, 0);
      chk("R10 done_flag", done_flag, 0);
      chk("R10 irq", irq, 0);

      // R6: power-up latency with pin low
      supply_ok = 1'b1;
      cnt = 0;
      do begin
         @(posedge clk); #1; cnt++;
         if (cnt < D) chk("R6 mod_en during init", mod_en, 0);
      end while (!done_flag && cnt < 100);
      ep = 1;
      chk("R6 latency", cnt, D);
      chk("R6 mod_en restored", mod_en, 1);
      chk("R5 fault passes in run", lowp_fault_q, 1);
      chk("R8 irq with flag", irq, 1);
      do_clear("R7 single clear");
      chk("R8 irq after clear", irq, 0);

      // R1/R4/R5/R2: sweep pulse widths, both fault levels
      for (int w = 1; w <= M + 2; w++) begin
         lowp_fault = w[0];
         pulse(w, 1'b1, 1'b0);
         if (ep != 0) do_clear("R7 clear after sweep");
      end
      lowp_fault = 1'b1;

      // R3: power-up with pin high
      @(negedge clk); supply_ok = 1'b0; pdrst_in = 1'b1; ep = 0;
      repeat (2) @(negedge clk);
      supply_ok = 1'b1;
      repeat (D) @(posedge clk);
      #1;
      ep = 1;
      chk("R3 done from power-up", done_flag, 1);
      chk("R3 stays powered down", mod_en, 0);
      chk("R2 irq masked in power-down", irq, 0);
      repeat (10) @(posedge clk);
      #1;
      chk("R3 still powered down", bias_en, 0);
      chk("R5 fault blanked", lowp_fault_q, 0);
      chk("R2 irq still masked", irq, 0);
      @(negedge clk); pdrst_in = 1'b0;
      cnt = 0;
      do begin @(posedge clk); #1; cnt++; end while (!mod_en && cnt < 100);
      ep = 2;
      chk("R4 release latency", cnt, N + D + 1);
      chk("R8 irq after release", irq, 1);
      do_clear("R7 first of two clears");
      chk("R8 irq one pending", irq, 1);
      do_clear("R7 second of two clears");
      do_clear("R7 clear at zero");
      chk("R7 no underflow irq", irq, 0);

      // R7: saturation after three completions
      for (int i = 0; i < 3; i++) pulse(M, 1'b0, 1'b0);
      chk("R7 saturated flag", done_flag, 1);
      do_clear("R7 saturated first clear");
      do_clear("R7 saturated second clear");

      // R9: clear coincident with completion
      pulse(M, 1'b0, 1'b0);
      pulse(M + 1, 1'b1, 1'b1);
      chk("R9 count held at one", done_flag, 1);
      do_clear("R9 one clear empties");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule